// File: doc/BRIEF.md
# Timer Interrupt Status Flags and Event Requests

This block keeps the interrupt status word of a small two-channel general-purpose timer. The timer core gives it single-cycle event pulses. These are a repetition counter overflow or underflow, a software update request, a counter reinitialisation by trigger, a capture or compare event on channel 1 and on channel 2, a commutation event and a trigger event. The block latches each event into a sticky flag. Software reads the flags and clears each one by writing 0 to its bit. A write of 1 to a bit does nothing.

A second word holds the enables. Interrupt enable bits sit at the same positions as their flags, so the interrupt output is the OR of every flag that has its enable set. The DMA request enables are bit 9 for channel 1, bit 10 for channel 2 and bit 14 for trigger. Each enabled DMA request is a one-cycle pulse in the cycle after its event, which is also the cycle in which the flag first reads 1.

Each flag is a two-state machine with the states `FLG_IDLE` and `FLG_PEND`. The transition `FLG_IDLE -> FLG_PEND` happens on a set pulse. The transition `FLG_PEND -> FLG_IDLE` happens on a clear with no set in the same cycle. In every other case the state holds. Reading a channel's capture/compare register over the bus also clears that channel's flag.

Top module: `tmr_evt_flags`

## Requirements
- R1: After reset the status read value is 0x0000, the control read value is 0x0000, and `irq`, `dma_ch1`, `dma_ch2` and `dma_trig` are all 0.
- R2: A status write clears every flag whose data bit is 0. A flag whose data bit is 1 keeps its value. Flag positions: bit 0 update, bit 1 channel 1, bit 2 channel 2, bit 5 commutation, bit 6 trigger.
- R3: If a flag's set event and its clear (by write or by capture/compare read) occur in the same cycle, the flag reads 1 afterwards.
- R4: A repetition counter overflow or underflow sets bit 0 only when `upd_disable` is 0. Otherwise bit 0 is unchanged.
- R5: A software update request or a trigger reinitialisation sets bit 0 only when both `upd_disable` and `upd_src_sel` are 0.
- R6: `evt_ch1` sets bit 1 and `evt_ch2` sets bit 2. A pulse on `ccr1_rd` clears bit 1 and a pulse on `ccr2_rd` clears bit 2.
- R7: `evt_com` sets bit 5 and `evt_trig` sets bit 6.
- R8: Reserved bits read 0 and ignore writes. Status bits 15:7 and 4:3 are reserved. Control bits 15, 13:11, 8:7 and 4:3 are reserved, so writing 0xFFFF to control reads back 0x4667.
- R9: `irq` is 1 exactly when some flag and the control bit at the same position are both 1.
- R10: With control bit 9, 10 or 14 set, an `evt_ch1`, `evt_ch2` or `evt_trig` pulse gives a single-cycle pulse on `dma_ch1`, `dma_ch2` or `dma_trig` in the next cycle. With the bit clear, there is no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_rep_ovf | input | 1 | Repetition counter overflow/underflow pulse |
| evt_sw_upd | input | 1 | Software update request pulse |
| evt_trig_reinit | input | 1 | Counter reinitialised by trigger pulse |
| upd_disable | input | 1 | Update-disable control bit |
| upd_src_sel | input | 1 | Update-source-select control bit |
| evt_ch1 | input | 1 | Channel 1 capture/compare event pulse |
| evt_ch2 | input | 1 | Channel 2 capture/compare event pulse |
| evt_com | input | 1 | Commutation event pulse |
| evt_trig | input | 1 | Trigger event pulse |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 16 | Status write data (0 clears) |
| ctl_wr | input | 1 | Enable word write strobe |
| ctl_wdata | input | 16 | Enable word write data |
| ccr1_rd | input | 1 | Channel 1 capture/compare register read strobe |
| ccr2_rd | input | 1 | Channel 2 capture/compare register read strobe |
| sts_rdata | output | 16 | Status word |
| ctl_rdata | output | 16 | Enable word |
| irq | output | 1 | Combined interrupt request |
| dma_ch1 | output | 1 | Channel 1 DMA request pulse |
| dma_ch2 | output | 1 | Channel 2 DMA request pulse |
| dma_trig | output | 1 | Trigger DMA request pulse |

## Verification
The assertions assume that each event input and each read strobe is a pulse sampled at one clock edge. They also assume the control bits `upd_disable` and `upd_src_sel` are steady during the cycle in which they gate an update source. The bench drives every input on the falling edge, holds it for exactly one rising edge and then clears it. This keeps each stimulus a single sampled pulse with stable gating bits. Coincident set and clear cases are applied within one such cycle.

// File: rtl/tmr_flags_pkg.sv
package tmr_flags_pkg;
    localparam int WORD_W    = 16;
    localparam int NUM_FLAGS = 5;
    localparam int NUM_DMA   = 3;

    // Bit positions of the flags; interrupt enables share them.
    localparam int FLAG_POS [NUM_FLAGS] = '{0, 1, 2, 5, 6};
    // Bit positions of DMA enables: channel 1, channel 2, trigger.
    localparam int DMA_POS  [NUM_DMA]   = '{9, 10, 14};

    localparam int IDX_UPD = 0;
    localparam int IDX_CH1 = 1;
    localparam int IDX_CH2 = 2;
    localparam int IDX_COM = 3;
    localparam int IDX_TRG = 4;

    localparam logic [WORD_W-1:0] STS_MASK = 16'h0067;
    localparam logic [WORD_W-1:0] CTL_MASK = 16'h4667;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;
endpackage

// File: rtl/tmr_upd_gate.sv
module tmr_upd_gate (
    input  logic rep_ovf,
    input  logic sw_upd,
    input  logic trig_reinit,
    input  logic upd_disable,
    input  logic upd_src_sel,
    output logic upd_set
);
    logic any_src_ok;
    logic counter_src_ok;

    always_comb begin
        // Counter over/underflow is only blocked by the disable bit.
        counter_src_ok = rep_ovf && !upd_disable;
        // Software and trigger sources also need source-select low.
        any_src_ok     = (sw_upd || trig_reinit) && !upd_disable && !upd_src_sel;
        upd_set        = counter_src_ok || any_src_ok;
    end
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell
    import tmr_flags_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set_i)           state_d = FLG_PEND;
            FLG_PEND: if (clr_i && !set_i) state_d = FLG_IDLE;
            default:                       state_d = FLG_IDLE;
        endcase
    end

    always_comb flag_o = (state_q == FLG_PEND);

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_clear_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/tmr_dma_req.sv
module tmr_dma_req #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] req_o
);
    for (genvar i = 0; i < N; i++) begin : g_req
        always_ff @(posedge clk) begin
            if (!rst_n) req_o[i] <= 1'b0;
            else        req_o[i] <= evt_i[i] && en_i[i];
        end

        assert_dma_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
            req_o[i] |-> $past(evt_i[i] && en_i[i]));
        assert_dma_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[i] && en_i[i]) |=> req_o[i]);
    end
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
    import tmr_flags_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        evt_rep_ovf,
    input  logic        evt_sw_upd,
    input  logic        evt_trig_reinit,
    input  logic        upd_disable,
    input  logic        upd_src_sel,
    input  logic        evt_ch1,
    input  logic        evt_ch2,
    input  logic        evt_com,
    input  logic        evt_trig,
    input  logic        sts_wr,
    input  logic [15:0] sts_wdata,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_wdata,
    input  logic        ccr1_rd,
    input  logic        ccr2_rd,
    output logic [15:0] sts_rdata,
    output logic [15:0] ctl_rdata,
    output logic        irq,
    output logic        dma_ch1,
    output logic        dma_ch2,
    output logic        dma_trig
);
    logic                 upd_set;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] rd_clr;
    logic [WORD_W-1:0]    ctl_q;
    logic [NUM_DMA-1:0]   dma_evt;
    logic [NUM_DMA-1:0]   dma_en;
    logic [NUM_DMA-1:0]   dma_req;

    tmr_upd_gate u_gate (
        .rep_ovf     (evt_rep_ovf),
        .sw_upd      (evt_sw_upd),
        .trig_reinit (evt_trig_reinit),
        .upd_disable (upd_disable),
        .upd_src_sel (upd_src_sel),
        .upd_set     (upd_set)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[IDX_UPD] = upd_set;
        flag_set[IDX_CH1] = evt_ch1;
        flag_set[IDX_CH2] = evt_ch2;
        flag_set[IDX_COM] = evt_com;
        flag_set[IDX_TRG] = evt_trig;
        rd_clr            = '0;
        rd_clr[IDX_CH1]   = ccr1_rd;
        rd_clr[IDX_CH2]   = ccr2_rd;
    end

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        always_comb flag_clr[f] = (sts_wr && !sts_wdata[FLAG_POS[f]]) || rd_clr[f];

        tmr_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[f]),
            .clr_i  (flag_clr[f]),
            .flag_o (flag_q[f])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_wdata & CTL_MASK;
    end

    always_comb begin
        sts_rdata = '0;
        for (int f = 0; f < NUM_FLAGS; f++) sts_rdata[FLAG_POS[f]] = flag_q[f];
        ctl_rdata = ctl_q;
        irq       = |(sts_rdata & ctl_q & STS_MASK);
        dma_evt   = {evt_trig, evt_ch2, evt_ch1};
        for (int d = 0; d < NUM_DMA; d++) dma_en[d] = ctl_q[DMA_POS[d]];
    end

    tmr_dma_req #(.N(NUM_DMA)) u_dma (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (dma_evt),
        .en_i  (dma_en),
        .req_o (dma_req)
    );

    always_comb begin
        dma_ch1  = dma_req[0];
        dma_ch2  = dma_req[1];
        dma_trig = dma_req[2];
    end

    assert_upd_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_disable && !sts_rdata[0]) |=> !sts_rdata[0]);
    assert_src_sel_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_src_sel && !evt_rep_ovf && !sts_rdata[0]) |=> !sts_rdata[0]);
    assert_ccr_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr1_rd && !evt_ch1) |=> !sts_rdata[1]);
    assert_ch_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_rdata[2]) |-> $past(evt_ch2));
endmodule

// File: tb/tb_tmr_evt_flags.sv
module tb_tmr_evt_flags;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_rep_ovf = 0, evt_sw_upd = 0, evt_trig_reinit = 0;
    logic upd_disable = 0, upd_src_sel = 0;
    logic evt_ch1 = 0, evt_ch2 = 0, evt_com = 0, evt_trig = 0;
    logic sts_wr = 0, ctl_wr = 0, ccr1_rd = 0, ccr2_rd = 0;
    logic [15:0] sts_wdata = '0, ctl_wdata = '0;
    logic [15:0] sts_rdata, ctl_rdata;
    logic irq, dma_ch1, dma_ch2, dma_trig;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;   // 125 MHz

    tmr_evt_flags dut (.*);

    // ev bits: 0 ovf, 1 sw update, 2 trig reinit, 3 ch1, 4 ch2, 5 com, 6 trig
    typedef struct packed {
        logic [6:0]  ev;
        logic        udis;
        logic        usel;
        logic        swr;
        logic [15:0] wdat;
        logic        rd1;
        logic        rd2;
        logic [15:0] exp_sts;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{7'h01, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0001, 8'd4},
        '{7'h00, 1'b0, 1'b0, 1'b1, 16'hFFFE, 1'b0, 1'b0, 16'h0000, 8'd2},
        '{7'h01, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd4},
        '{7'h02, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd5},
        '{7'h02, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0001, 8'd5},
        '{7'h00, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd2},
        '{7'h04, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'd5},
        '{7'h04, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0001, 8'd5},
        '{7'h18, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0007, 8'd6},
        '{7'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0005, 8'd6},
        '{7'h60, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0065, 8'd7},
        '{7'h00, 1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'h0065, 8'd2},
        '{7'h08, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 16'h0002, 8'd3},
        '{7'h10, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0006, 8'd3},
        '{7'h00, 1'b0, 1'b0, 1'b1, 16'hFFFD, 1'b0, 1'b0, 16'h0004, 8'd2}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        {evt_rep_ovf, evt_sw_upd, evt_trig_reinit, evt_ch1, evt_ch2, evt_com, evt_trig} = '0;
        {sts_wr, ctl_wr, ccr1_rd, ccr2_rd, upd_disable, upd_src_sel} = '0;
        sts_wdata = '0;
        ctl_wdata = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 sts", sts_rdata, 16'h0000);
        check("R1 ctl", ctl_rdata, 16'h0000);
        check("R1 outs", {12'h0, irq, dma_ch1, dma_ch2, dma_trig}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            {evt_trig, evt_com, evt_ch2, evt_ch1, evt_trig_reinit, evt_sw_upd, evt_rep_ovf} = VEC[i].ev;
            upd_disable = VEC[i].udis;
            upd_src_sel = VEC[i].usel;
            sts_wr      = VEC[i].swr;
            sts_wdata   = VEC[i].wdat;
            ccr1_rd     = VEC[i].rd1;
            ccr2_rd     = VEC[i].rd2;
            step();
            check($sformatf("R%0d vec %0d", VEC[i].req, i), sts_rdata, VEC[i].exp_sts);
        end

        // R8: reserved bits of control ignore writes
        ctl_wr = 1'b1; ctl_wdata = 16'hFFFF; step();
        check("R8 ctl reserved", ctl_rdata, 16'h4667);
        // R8: reserved status bits stay 0 after write of ones
        sts_wr = 1'b1; sts_wdata = 16'hFFFF; step();
        check("R8 sts reserved", sts_rdata, 16'h0004);

        // R9: only ch1 interrupt enabled; ch2 flag pending
        ctl_wr = 1'b1; ctl_wdata = 16'h0002; step();
        check("R9 irq masked", {15'h0, irq}, 16'h0000);
        evt_ch1 = 1'b1; step();
        check("R9 irq asserted", {15'h0, irq}, 16'h0001);
        ccr1_rd = 1'b1; step();
        check("R9 irq dropped", {15'h0, irq}, 16'h0000);

        // R10: ch1 and trig DMA enabled, ch2 disabled
        ctl_wr = 1'b1; ctl_wdata = 16'h4200; step();
        evt_ch1 = 1'b1; evt_ch2 = 1'b1; evt_trig = 1'b1; step();
        check("R10 pulse", {13'h0, dma_ch1, dma_ch2, dma_trig}, 16'h0005);
        step();
        check("R10 width", {13'h0, dma_ch1, dma_ch2, dma_trig}, 16'h0000);
        // R7 trigger flag seen too
        check("R7 trig flag", sts_rdata & 16'h0040, 16'h0040);

        summary();
    end
endmodule